// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves a single fixed-size page between a card-side page buffer and system memory. The transfer runs as two separate phases. The internal phase moves the page between the card and the on-board buffer. The memory phase moves it between the buffer and system memory as a run of word beats. Software sets a direction bit and a memory base address, then arms one phase at a time by writing a phase-select bit. Each phase ends with its own status bit. After the first phase ends, software must arm the other phase before the transfer can go on. A read runs the internal phase first and a write runs the memory phase first. A stage counter, readable by software, shows how far the transfer has got.

The engine has three states. `ST_IDLE` waits for an arm. `ST_CARD` holds the card request until the card reports done or error. `ST_MEM` issues word beats under a ready handshake.

The transitions are:
- `ST_IDLE` to `ST_CARD` on an accepted arm with the internal select set.
- `ST_IDLE` to `ST_MEM` on an accepted arm with only the memory select set.
- `ST_CARD` to `ST_IDLE` on card done, card error or abort.
- `ST_MEM` to `ST_IDLE` on the last accepted beat, a memory error or abort.

The status bits are write-one-to-clear. A single interrupt line is the OR of every status bit whose enable bit is set.

Register offsets on `reg_addr`:

| Offset | Register | Fields |
|---|---|---|
| 0 | settings | bit0 read direction, bit1 internal-phase select, bit2 memory-phase select |
| 1 | memory base address | full word |
| 2 | interrupt enable | same bit positions as the status register |
| 3 | interrupt status | bit0 internal done, bit1 memory done, bit2 error |
| 4 | capability | read only |
| 5 | stage | read only, values 0..3 |

Top module: `pdma_page_seq`

## Requirements
- R1: After reset the stage reads 0, the status reads 0, `irq` is low, and neither `card_go` nor `mem_req` is asserted.
- R2: A settings write (offset 0) is accepted as an arm when it sets bit1 or bit2, the engine is idle and the stage is 0 or 2. If bit1 is set, the internal phase runs, even when bit2 is also set; otherwise the memory phase runs. An arm at stage 0 moves the stage to 1.
- R3: During the internal phase `card_go` stays high and `card_to_buf` equals settings bit0 until a `card_done` pulse. The phase then ends and status bit0 is set.
- R4: The memory phase issues exactly 128 accepted beats at addresses base+4k for k = 0..127. Address and request hold while `mem_ready` is low, and `mem_write` equals settings bit0. When the last beat is accepted, status bit1 is set.
- R5: When a phase completes at stage 1 the stage moves to 2. The stage stays 2 while the re-armed second phase runs. When that phase completes the stage becomes 3. The stage is readable at offset 5.
- R6: `card_err` during the internal phase, or `mem_err` during a memory beat, sets status bit2, stops the engine in the next cycle and returns the stage to 0.
- R7: Writing ones to offset 3 clears those status bits, and bits written as zero are kept. A hardware set in the same cycle as a clear wins.
- R8: `irq` is high exactly when some status bit and the enable bit at the same position in offset 2 are both set. Enables of 0 keep `irq` low while status is set.
- R9: Writing 0 to the settings register aborts any phase at once, returns the stage to 0 and sets no status bit.
- R10: An arm written while a phase runs or at stage 3 is ignored, and so is a base write during a phase. The running transfer and its addresses are unchanged, and settings reads back the last accepted value.
- R11: The capability register at offset 4 reads 0x3, meaning both phases are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| card_go | output | 1 | Internal-phase request, held until done or error |
| card_to_buf | output | 1 | 1: card to buffer, 0: buffer to card |
| card_done | input | 1 | One-cycle internal-phase completion |
| card_err | input | 1 | Internal-phase error |
| mem_req | output | 1 | Memory beat request |
| mem_write | output | 1 | 1: beat writes system memory |
| mem_addr | output | 32 | Byte address of the current beat |
| buf_idx | output | 7 | Buffer word index of the current beat |
| mem_ready | input | 1 | Beat accepted when high with `mem_req` |
| mem_err | input | 1 | Memory beat error |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that:
- a stalled beat holds its address;
- an accepted beat steps the address by one word;
- an error or an abort drops both requests and clears the stage in the next cycle;
- a running phase always shows stage 1 or 2;
- status clears obey write-one-to-clear while hardware sets win.

Only the bench scenarios can show the rest: the whole two-phase order for reads and writes, the beat count over a full page, the direction outputs, the ignoring of arms and base writes at the wrong time, interrupt masking, and the capability value.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CARD = 2'd1,
        ST_MEM  = 2'd2
    } pdma_state_e;

    localparam logic [2:0] OFF_SETTINGS = 3'd0;
    localparam logic [2:0] OFF_BASE     = 3'd1;
    localparam logic [2:0] OFF_IEN      = 3'd2;
    localparam logic [2:0] OFF_ISTAT    = 3'd3;
    localparam logic [2:0] OFF_CAP      = 3'd4;
    localparam logic [2:0] OFF_STAGE    = 3'd5;

    localparam int CFG_DIR  = 0;
    localparam int CFG_INT  = 1;
    localparam int CFG_MEM  = 2;

    localparam int EV_INT   = 0;
    localparam int EV_MEM   = 1;
    localparam int EV_ERR   = 2;
    localparam int NUM_EV   = 3;

    localparam logic [31:0] CAP_VALUE = 32'h0000_0003;
endpackage

// File: rtl/pdma_beat_ctr.sv
module pdma_beat_ctr #(
    parameter int BEATS = 128,
    localparam int BW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [BW-1:0] idx,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx <= '0;
        else if (clear)   idx <= '0;
        else if (advance) idx <= idx + 1'b1;
    end

    assign last = (idx == BW'(BEATS - 1));
endmodule

// File: rtl/pdma_irq_ctl.sv
module pdma_irq_ctl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ien_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | set_i;
    end

    assign irq_o = |(status_o & ien_i);

    // R7: cleared bits without a concurrent set read back as zero
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    // R7: a hardware set always lands, even against a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/pdma_page_seq.sv
module pdma_page_seq
    import pdma_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int BEAT_BYTES = 4,
    parameter int AW         = 32,
    localparam int BEATS     = PAGE_BYTES / BEAT_BYTES,
    localparam int BW        = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          card_go,
    output logic          card_to_buf,
    input  logic          card_done,
    input  logic          card_err,
    output logic          mem_req,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] buf_idx,
    input  logic          mem_ready,
    input  logic          mem_err,
    output logic          irq
);
    pdma_state_e       state_q, state_d;
    logic [2:0]        cfg_q;
    logic [AW-1:0]     base_q;
    logic [NUM_EV-1:0] ien_q, status, ev_set, ev_clr;
    logic [1:0]        stage_q;
    logic              wr_cfg, abort, arm, ev_int, ev_mem, ev_err;
    logic              beat_adv, beat_last;
    logic [BW-1:0]     beat_idx;

    assign wr_cfg = reg_wr && (reg_addr == OFF_SETTINGS);
    assign abort  = wr_cfg && (reg_wdata[2:0] == 3'b000);
    assign arm    = wr_cfg && (reg_wdata[CFG_INT] || reg_wdata[CFG_MEM])
                    && (state_q == ST_IDLE) && (stage_q == 2'd0 || stage_q == 2'd2);

    // next-state selection
    always_comb begin
        state_d = state_q;
        ev_int  = 1'b0;
        ev_mem  = 1'b0;
        ev_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = reg_wdata[CFG_INT] ? ST_CARD : ST_MEM;
            end
            ST_CARD: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (card_err) begin
                    state_d = ST_IDLE;
                    ev_err  = 1'b1;
                end else if (card_done) begin
                    state_d = ST_IDLE;
                    ev_int  = 1'b1;
                end
            end
            ST_MEM: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (mem_err) begin
                    state_d = ST_IDLE;
                    ev_err  = 1'b1;
                end else if (mem_ready && beat_last) begin
                    state_d = ST_IDLE;
                    ev_mem  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            base_q  <= '0;
            ien_q   <= '0;
            stage_q <= 2'd0;
        end else begin
            state_q <= state_d;
            if (arm || abort) cfg_q <= reg_wdata[2:0];
            if (reg_wr && reg_addr == OFF_BASE && state_q == ST_IDLE)
                base_q <= reg_wdata[AW-1:0];
            if (reg_wr && reg_addr == OFF_IEN) ien_q <= reg_wdata[NUM_EV-1:0];
            if (abort || ev_err)         stage_q <= 2'd0;
            else if (arm && stage_q == 2'd0) stage_q <= 2'd1;
            else if (ev_int || ev_mem)   stage_q <= (stage_q == 2'd1) ? 2'd2 : 2'd3;
        end
    end

    assign beat_adv = (state_q == ST_MEM) && mem_ready && !mem_err && !abort;

    pdma_beat_ctr #(.BEATS(BEATS)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (arm),
        .advance (beat_adv),
        .idx     (beat_idx),
        .last    (beat_last)
    );

    assign ev_set = {ev_err, ev_mem, ev_int};
    assign ev_clr = (reg_wr && reg_addr == OFF_ISTAT) ? reg_wdata[NUM_EV-1:0] : '0;

    pdma_irq_ctl #(.N(NUM_EV)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_set),
        .clr_i    (ev_clr),
        .ien_i    (ien_q),
        .status_o (status),
        .irq_o    (irq)
    );

    // outputs
    always_comb begin
        card_go     = (state_q == ST_CARD);
        card_to_buf = cfg_q[CFG_DIR];
        mem_req     = (state_q == ST_MEM);
        mem_write   = cfg_q[CFG_DIR];
        mem_addr    = base_q + AW'(beat_idx) * AW'(BEAT_BYTES);
        buf_idx     = beat_idx;
        unique case (reg_addr)
            OFF_SETTINGS: reg_rdata = 32'(cfg_q);
            OFF_BASE:     reg_rdata = 32'(base_q);
            OFF_IEN:      reg_rdata = 32'(ien_q);
            OFF_ISTAT:    reg_rdata = 32'(status);
            OFF_CAP:      reg_rdata = CAP_VALUE;
            OFF_STAGE:    reg_rdata = 32'(stage_q);
            default:      reg_rdata = 32'h0;
        endcase
    end

    // R4: a stalled beat keeps its request and address
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !mem_err && !abort) |=> (mem_req && $stable(mem_addr)));

    // R4: an accepted beat that is not the last steps by one word
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_err && !abort && !beat_last)
        |=> (mem_req && mem_addr == $past(mem_addr) + AW'(BEAT_BYTES)));

    // R6: an error stops both requests at once and flags status
    a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && ((card_go && card_err) || (mem_req && mem_err)))
        |=> (!card_go && !mem_req && stage_q == 2'd0 && status[EV_ERR]));

    // R9: an abort drops any phase and the stage
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!card_go && !mem_req && stage_q == 2'd0));

    // R5: a running phase is always the first or second stage
    a_r5_stage_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (card_go || mem_req) |-> (stage_q == 2'd1 || stage_q == 2'd2));
endmodule

// File: tb/pdma_page_seq_bench.sv
module pdma_page_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        card_go, card_to_buf, mem_req, mem_write, irq;
    logic        card_done = 1'b0, card_err = 1'b0;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr;
    logic [6:0]  buf_idx;

    int checks = 0;
    int errors = 0;

    // main-driven knobs
    logic [31:0] cur_base = 32'h0;
    int card_lat = 3;
    int card_err_req = 0;
    int mem_err_req = 0;
    int mem_err_at = 0;
    // responder-owned records
    int card_err_srv = 0;
    int mem_err_srv = 0;
    int card_cnt = 0;
    int phase_beats = 0;
    int addr_bad = 0;
    logic prev_req = 1'b0;
    logic last_card_dir = 1'b0;
    logic last_mem_wr = 1'b0;

    always #5 clk = ~clk;

    pdma_page_seq u_pdma_page_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_go(card_go),
        .card_to_buf(card_to_buf), .card_done(card_done), .card_err(card_err),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .buf_idx(buf_idx), .mem_ready(mem_ready), .mem_err(mem_err), .irq(irq)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
        return base + 32'(k) * 32'd4;
    endfunction

    // card and memory responders
    always @(negedge clk) begin
        card_done = 1'b0;
        card_err  = 1'b0;
        if (card_go) begin
            card_cnt = card_cnt + 1;
            last_card_dir = card_to_buf;
            if (card_err_req != card_err_srv && card_cnt == 1) begin
                card_err = 1'b1;
                card_err_srv = card_err_req;
            end else if (card_cnt == card_lat) begin
                card_done = 1'b1;
            end
        end else begin
            card_cnt = 0;
        end

        mem_err   = 1'b0;
        mem_ready = ($urandom % 4) != 0;
        if (mem_req && !prev_req) phase_beats = 0;
        prev_req = mem_req;
        if (mem_req) begin
            last_mem_wr = mem_write;
            if (mem_err_req != mem_err_srv && phase_beats == mem_err_at) begin
                mem_err = 1'b1;
                mem_err_srv = mem_err_req;
            end else if (mem_ready) begin
                if (mem_addr != exp_addr(cur_base, phase_beats)) addr_bad = addr_bad + 1;
                phase_beats = phase_beats + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input int b);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd3, v);
            if (v[b]) break;
            @(negedge clk);
        end
    endtask

    // full two-phase transfer; leaves the stage at 3
    task automatic do_xfer(input logic dir_rd, input logic [31:0] base);
        logic [31:0] v;
        int fb, sb;
        wr(3'd1, base);
        cur_base = base;
        wr(3'd2, 32'h7);
        card_lat = 2 + int'($urandom % 5);
        fb = dir_rd ? 0 : 1;
        sb = dir_rd ? 1 : 0;
        wr(3'd0, dir_rd ? 32'h3 : 32'h4);
        rd(3'd5, v); chk("R5 stage after first arm", v, 32'd1);
        wait_bit(fb);
        rd(3'd5, v); chk("R5 stage after first phase", v, 32'd2);
        rd(3'd3, v); chk("R3/R4 first phase status", v, 32'(1 << fb));
        chk("R8 irq with enable", 32'(irq), 32'd1);
        wr(3'd3, 32'(1 << fb));
        rd(3'd3, v); chk("R7 status cleared", v, 32'd0);
        chk("R8 irq after clear", 32'(irq), 32'd0);
        wr(3'd0, dir_rd ? 32'h5 : 32'h2);
        wait_bit(sb);
        rd(3'd5, v); chk("R5 stage done", v, 32'd3);
        chk("R4 beat count", 32'(phase_beats), 32'd128);
        chk("R4 mem_write follows dir", 32'(last_mem_wr), 32'(dir_rd));
        chk("R3 card_to_buf follows dir", 32'(last_card_dir), 32'(dir_rd));
        wr(3'd3, 32'h7);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd5, v); chk("R1 reset stage", v, 32'd0);
        rd(3'd3, v); chk("R1 reset status", v, 32'd0);
        chk("R1 reset irq", 32'(irq), 32'd0);
        chk("R1 reset requests", 32'({card_go, mem_req}), 32'd0);
        rd(3'd4, v); chk("R11 capability", v, 32'h3);

        // directed read then write
        do_xfer(1'b1, 32'h1000_0000);
        // R10: at stage 3 an arm is ignored
        wr(3'd0, 32'h3);
        @(negedge clk);
        chk("R10 no restart at stage 3", 32'(card_go), 32'd0);
        rd(3'd5, v); chk("R10 stage stays 3", v, 32'd3);
        wr(3'd0, 32'h0);
        rd(3'd5, v); chk("R9 abort clears stage", v, 32'd0);
        do_xfer(1'b0, 32'h2000_0100);
        wr(3'd0, 32'h0);

        // R10: arm and base writes during a memory phase are ignored
        wr(3'd1, 32'h3000_0000);
        cur_base = 32'h3000_0000;
        wr(3'd0, 32'h4);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'h3);
        wr(3'd1, 32'h5555_0000);
        chk("R10 no card request mid phase", 32'(card_go), 32'd0);
        rd(3'd0, v); chk("R10 settings keeps accepted value", v, 32'h4);
        wait_bit(1);
        chk("R10 full page despite pokes", 32'(phase_beats), 32'd128);
        wr(3'd3, 32'h7);
        wr(3'd0, 32'h0);

        // R2: both selects start the internal phase; R9 abort mid phase
        card_lat = 50;
        wr(3'd0, 32'h7);
        chk("R2 internal priority card_go", 32'(card_go), 32'd1);
        chk("R2 internal priority no mem_req", 32'(mem_req), 32'd0);
        wr(3'd0, 32'h0);
        chk("R9 abort drops card_go", 32'(card_go), 32'd0);
        rd(3'd3, v); chk("R9 abort sets no status", v, 32'd0);

        // R6: memory error mid page
        mem_err_at = 10;
        mem_err_req = mem_err_req + 1;
        wr(3'd0, 32'h4);
        wait_bit(2);
        rd(3'd3, v); chk("R6 mem error status", v, 32'h4);
        rd(3'd5, v); chk("R6 mem error stage", v, 32'd0);
        chk("R6 mem error stops requests", 32'(mem_req), 32'd0);
        chk("R6 beats before error", 32'(phase_beats), 32'd10);
        wr(3'd3, 32'h4);

        // R6: card error
        card_lat = 5;
        card_err_req = card_err_req + 1;
        wr(3'd0, 32'h3);
        wait_bit(2);
        rd(3'd5, v); chk("R6 card error stage", v, 32'd0);
        chk("R6 card error stops card_go", 32'(card_go), 32'd0);
        wr(3'd3, 32'h7);

        // R8: masked enables
        wr(3'd2, 32'h0);
        card_lat = 3;
        wr(3'd0, 32'h3);
        wait_bit(0);
        chk("R8 masked irq low", 32'(irq), 32'd0);
        wr(3'd2, 32'h1);
        chk("R8 enabled irq high", 32'(irq), 32'd1);
        wr(3'd3, 32'h7);
        wr(3'd0, 32'h0);

        // constrained random transfers
        for (int n = 0; n < 6; n++) begin
            do_xfer(1'($urandom % 2), $urandom & 32'hFFFF_FFFC);
            wr(3'd0, 32'h0);
        end

        chk("R4 every beat address", 32'(addr_bad), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule